// File: doc/BRIEF.md
# Operand Bypass Unit

This block chooses where each operand of the instruction now in the execute stage of a five-stage in-order pipeline comes from. There are three operand paths: the first ALU input, the second ALU input and the data that a store writes to memory. Each path takes one of three values. The first is the value read from the register file during decode. The second is the ALU result held in the execute/memory pipeline register. The third is the result held in the memory/writeback pipeline register, which is either an ALU result or load data. The choice depends on the source register fields of the consumer and on the destination, write flag and instruction class of the two older instructions still in flight.

The destination field sits in a different place for each class. Register-register operations name it in one field. Register-immediate operations and loads name it in the field that other classes use as the second source. Stores and all remaining classes write nothing. Register 0 reads as zero and is never bypassed. The register file writes early in a cycle and reads late, so a producer three slots older is already visible there. A small pipeline is wrapped around the select logic: a decode/execute register, an adder, execute/memory and memory/writeback registers, and a load-data input. This lets the forwarded values be seen at the ports.

Top module: `operand_bypass_unit`

## Requirements
- R1: The instruction word carries the opcode in [31:26], source 1 in [25:21], source 2 in [20:16] and the immediate in [15:0]. Opcode 0 is register-register, 1 is register-immediate, 2 is load, 3 is store, and every other opcode is a non-writing class that reads source 1 only. Select codes are 0 for the register file, 1 for the execute/memory ALU result and 2 for the memory/writeback result. Code 3 never appears.
- R2: A register-register instruction writes the register named in [15:11]. Register-immediate instructions and loads write the register named in [20:16]. Stores and the other classes write no register.
- R3: When the execute/memory slot holds a non-load writer whose destination equals a source being used, that path selects 1 and the operand equals that instruction's ALU result.
- R4: When the memory/writeback slot holds a writer, ALU or load, whose destination matches, the path selects 2. When both slots match, select 1 wins.
- R5: Source register 0 is never forwarded. Its select is 0 and its operand is 0.
- R6: A producer three or more slots older is not forwarded. The select is 0 and the register file value is used.
- R7: The first ALU select applies to every valid instruction. The second ALU select is nonzero only for register-register instructions. For all other classes the second operand is the sign-extended immediate.
- R8: The store-data select is nonzero only for a store. It forwards source 2, including load data from the memory/writeback slot.
- R9: A load in the execute/memory slot is never a source. The match falls through to the memory/writeback slot or the register file.
- R10: An invalid slot neither consumes nor produces. Its selects are 0, and it never matches a later consumer.
- R11: While reset is held, all slots are empty, all selects are 0 and the operand outputs are 0.
- R12: The execute result is operand A plus operand B. The memory/writeback result of a load is `mem_rdata`, sampled in the cycle the load occupies the memory stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_valid | input | 1 | Instruction leaving decode is valid |
| id_instr | input | 32 | Instruction word leaving decode |
| id_rs1_data | input | XLEN | Register file value of source 1 |
| id_rs2_data | input | XLEN | Register file value of source 2 |
| mem_rdata | input | XLEN | Load data for the instruction in the memory stage |
| sel_a | output | 2 | Bypass select, first ALU input |
| sel_b | output | 2 | Bypass select, second ALU input |
| sel_sd | output | 2 | Bypass select, store data |
| ex_opnd_a | output | XLEN | Selected first ALU operand |
| ex_opnd_b | output | XLEN | Selected second ALU operand or immediate |
| ex_store_data | output | XLEN | Selected store data |

## Verification
An instruction presented at decode reaches execute at the next rising edge. All three selects and operands for it are therefore due right after that single edge. The bench pushes the expected item when it drives the instruction and pops it 1 ns after the following edge. A load's data must be on `mem_rdata` during the cycle between its second and third edges. The bench drives it at the falling edge on which the instruction two slots younger is issued. The register file values handed to decode include only producers three or more slots older. Any gap in forwarding therefore shows up as a wrong operand at the ports.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int OP_W    = 6;

    typedef enum logic [2:0] {
        CLS_RR    = 3'd0,
        CLS_RI    = 3'd1,
        CLS_LOAD  = 3'd2,
        CLS_STORE = 3'd3,
        CLS_OTHER = 3'd4
    } iclass_e;

    typedef enum logic [1:0] {
        SEL_RF    = 2'd0,
        SEL_EXMEM = 2'd1,
        SEL_MEMWB = 2'd2
    } byp_sel_e;

    function automatic iclass_e classify(input logic [OP_W-1:0] op);
        iclass_e c;
        case (op)
            6'd0:    c = CLS_RR;
            6'd1:    c = CLS_RI;
            6'd2:    c = CLS_LOAD;
            6'd3:    c = CLS_STORE;
            default: c = CLS_OTHER;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bypass_dest_dec.sv
module bypass_dest_dec
    import bypass_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    output logic               wr_en,
    output logic [REG_W-1:0]   wr_idx,
    output logic               is_load
);
    iclass_e cls;
    logic    writes;

    always_comb begin
        cls     = classify(instr[31:26]);
        writes  = 1'b0;
        wr_idx  = '0;
        case (cls)
            CLS_RR: begin
                writes = 1'b1;
                wr_idx = instr[15:11];
            end
            CLS_RI, CLS_LOAD: begin
                writes = 1'b1;
                wr_idx = instr[20:16];
            end
            default: begin
                writes = 1'b0;
                wr_idx = '0;
            end
        endcase
        // a write to register 0 is discarded, so it can never match
        wr_en   = valid && writes && (wr_idx != '0);
        is_load = valid && (cls == CLS_LOAD);
    end
endmodule

// File: rtl/bypass_pick.sv
module bypass_pick
    import bypass_pkg::*;
(
    input  logic             use_en,
    input  logic [REG_W-1:0] src,
    input  logic             em_wen,
    input  logic             em_is_load,
    input  logic [REG_W-1:0] em_dest,
    input  logic             mw_wen,
    input  logic [REG_W-1:0] mw_dest,
    output logic [1:0]       sel
);
    logic em_hit;
    logic mw_hit;

    always_comb begin
        em_hit = em_wen && !em_is_load && (em_dest == src);
        mw_hit = mw_wen && (mw_dest == src);
        sel    = SEL_RF;
        if (use_en) begin
            if (em_hit)      sel = SEL_EXMEM;
            else if (mw_hit) sel = SEL_MEMWB;
        end
    end
endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
    import bypass_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_valid,
    input  logic [31:0]        id_instr,
    input  logic [XLEN-1:0]    id_rs1_data,
    input  logic [XLEN-1:0]    id_rs2_data,
    input  logic [XLEN-1:0]    mem_rdata,
    output logic [1:0]         sel_a,
    output logic [1:0]         sel_b,
    output logic [1:0]         sel_sd,
    output logic [XLEN-1:0]    ex_opnd_a,
    output logic [XLEN-1:0]    ex_opnd_b,
    output logic [XLEN-1:0]    ex_store_data
);
    localparam int NPATH   = 3;
    localparam int P_A     = 0;
    localparam int P_B     = 1;
    localparam int P_SD    = 2;
    localparam int IMM_W   = 16;
    localparam int EXT_W   = XLEN - IMM_W;

    // decode/execute slot
    logic               ex_valid;
    logic [INSTR_W-1:0] ex_instr;
    logic [XLEN-1:0]    ex_rs1;
    logic [XLEN-1:0]    ex_rs2;
    iclass_e            ex_cls;
    logic               ex_wen;
    logic [REG_W-1:0]   ex_dest;
    logic               ex_is_load;
    logic [XLEN-1:0]    ex_imm;
    logic [XLEN-1:0]    alu_out;

    // execute/memory slot
    logic               em_wen;
    logic               em_is_load;
    logic [REG_W-1:0]   em_dest;
    logic [XLEN-1:0]    em_result;

    // memory/writeback slot
    logic               mw_wen;
    logic [REG_W-1:0]   mw_dest;
    logic [XLEN-1:0]    mw_result;

    logic               use_en  [NPATH];
    logic [REG_W-1:0]   src_idx [NPATH];
    logic [1:0]         sel_arr [NPATH];

    function automatic logic [XLEN-1:0] pick_value(
        input logic [1:0]      sel,
        input logic [XLEN-1:0] rf_val,
        input logic [XLEN-1:0] em_val,
        input logic [XLEN-1:0] mw_val
    );
        logic [XLEN-1:0] v;
        case (sel)
            SEL_EXMEM: v = em_val;
            SEL_MEMWB: v = mw_val;
            default:   v = rf_val;
        endcase
        return v;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_valid <= 1'b0;
            ex_instr <= '0;
            ex_rs1   <= '0;
            ex_rs2   <= '0;
        end else begin
            ex_valid <= id_valid;
            ex_instr <= id_instr;
            ex_rs1   <= id_rs1_data;
            ex_rs2   <= id_rs2_data;
        end
    end

    bypass_dest_dec u_dec (
        .valid   (ex_valid),
        .instr   (ex_instr),
        .wr_en   (ex_wen),
        .wr_idx  (ex_dest),
        .is_load (ex_is_load)
    );

    always_comb begin
        ex_cls        = classify(ex_instr[31:26]);
        use_en[P_A]   = ex_valid;
        use_en[P_B]   = ex_valid && (ex_cls == CLS_RR);
        use_en[P_SD]  = ex_valid && (ex_cls == CLS_STORE);
        src_idx[P_A]  = ex_instr[25:21];
        src_idx[P_B]  = ex_instr[20:16];
        src_idx[P_SD] = ex_instr[20:16];
    end

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        bypass_pick u_pick (
            .use_en     (use_en[p]),
            .src        (src_idx[p]),
            .em_wen     (em_wen),
            .em_is_load (em_is_load),
            .em_dest    (em_dest),
            .mw_wen     (mw_wen),
            .mw_dest    (mw_dest),
            .sel        (sel_arr[p])
        );
    end

    assign sel_a  = sel_arr[P_A];
    assign sel_b  = sel_arr[P_B];
    assign sel_sd = sel_arr[P_SD];

    always_comb begin
        ex_imm        = {{EXT_W{ex_instr[IMM_W-1]}}, ex_instr[IMM_W-1:0]};
        ex_opnd_a     = pick_value(sel_a, ex_rs1, em_result, mw_result);
        ex_opnd_b     = (ex_cls == CLS_RR) ? pick_value(sel_b, ex_rs2, em_result, mw_result)
                                           : ex_imm;
        ex_store_data = pick_value(sel_sd, ex_rs2, em_result, mw_result);
        alu_out       = ex_opnd_a + ex_opnd_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            em_wen     <= 1'b0;
            em_is_load <= 1'b0;
            em_dest    <= '0;
            em_result  <= '0;
            mw_wen     <= 1'b0;
            mw_dest    <= '0;
            mw_result  <= '0;
        end else begin
            em_wen     <= ex_wen;
            em_is_load <= ex_is_load;
            em_dest    <= ex_dest;
            em_result  <= alu_out;
            mw_wen     <= em_wen;
            mw_dest    <= em_dest;
            mw_result  <= em_is_load ? mem_rdata : em_result;
        end
    end
endmodule

// File: rtl/bypass_checker.sv
module bypass_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ex_valid,
    input logic [5:0] ex_op,
    input logic [4:0] ex_src1,
    input logic [4:0] ex_rd,
    input logic [1:0] sel_a,
    input logic [1:0] sel_b,
    input logic [1:0] sel_sd
);
    assert_legal_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a != 2'd3) && (sel_b != 2'd3) && (sel_sd != 2'd3));

    assert_younger_alu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && $past(ex_valid) && $past(ex_op) == 6'd0 && $past(ex_rd) != 5'd0
         && ex_src1 == $past(ex_rd)) |-> (sel_a == 2'd1));

    assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src1 == 5'd0) |-> (sel_a == 2'd0));

    assert_b_only_rr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_b != 2'd0) |-> (ex_valid && ex_op == 6'd0));

    assert_sd_only_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_sd != 2'd0) |-> (ex_valid && ex_op == 6'd3));

    assert_load_not_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_op == 6'd2) |=> (sel_a != 2'd1 && sel_b != 2'd1 && sel_sd != 2'd1));

    assert_bubble_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_valid) |-> (sel_a == 2'd0 && sel_b == 2'd0 && sel_sd == 2'd0));
endmodule

bind operand_bypass_unit bypass_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_valid (ex_valid),
    .ex_op    (ex_instr[31:26]),
    .ex_src1  (ex_instr[25:21]),
    .ex_rd    (ex_instr[15:11]),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .sel_sd   (sel_sd)
);

// File: tb/operand_bypass_unit_tb.sv
module operand_bypass_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        id_valid;
    logic [31:0] id_instr, id_rs1_data, id_rs2_data, mem_rdata;
    logic [1:0]  sel_a, sel_b, sel_sd;
    logic [31:0] ex_opnd_a, ex_opnd_b, ex_store_data;

    always #5 clk = ~clk;

    operand_bypass_unit #(.XLEN(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_instr(id_instr),
        .id_rs1_data(id_rs1_data), .id_rs2_data(id_rs2_data), .mem_rdata(mem_rdata),
        .sel_a(sel_a), .sel_b(sel_b), .sel_sd(sel_sd),
        .ex_opnd_a(ex_opnd_a), .ex_opnd_b(ex_opnd_b), .ex_store_data(ex_store_data)
    );

    typedef struct {
        logic [1:0]  sa, sb, ssd;
        logic [31:0] va, vb, vsd;
        bit          chk_v, chk_sd;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] golden [32];
    logic [31:0] lagged [32];
    bit          h_wen [3];
    bit          h_ld  [3];
    logic [4:0]  h_dst [3];
    logic [31:0] h_val [3];

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_sel(input logic [4:0] src);
        if (src != 0 && h_wen[0] && !h_ld[0] && h_dst[0] == src) return 2'd1;
        if (src != 0 && h_wen[1] && h_dst[1] == src) return 2'd2;
        return 2'd0;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // driver: one slot per call
    task automatic issue(input bit v, input logic [5:0] op, input logic [4:0] rs1,
                         input logic [4:0] rs2, input logic [15:0] imm, input string tag);
        exp_t        e;
        logic [31:0] sx, a, b, res;
        logic [4:0]  dst;
        bit          wen, ld;
        @(negedge clk);
        if (h_wen[2]) lagged[h_dst[2]] = h_val[2];
        mem_rdata   = h_ld[1] ? h_val[1] : 32'h0;
        id_valid    = v;
        id_instr    = {op, rs1, rs2, imm};
        id_rs1_data = lagged[rs1];
        id_rs2_data = lagged[rs2];
        sx  = {{16{imm[15]}}, imm};
        a   = golden[rs1];
        b   = (op == 6'd0) ? golden[rs2] : sx;
        e.sa  = v ? exp_sel(rs1) : 2'd0;
        e.sb  = (v && op == 6'd0) ? exp_sel(rs2) : 2'd0;
        e.ssd = (v && op == 6'd3) ? exp_sel(rs2) : 2'd0;
        e.va  = a;
        e.vb  = b;
        e.vsd = golden[rs2];
        e.chk_v  = v && !(h_ld[0] && h_wen[0] && (h_dst[0] == rs1 || h_dst[0] == rs2));
        e.chk_sd = e.chk_v && (op == 6'd3);
        e.tag = tag;
        ld  = v && (op == 6'd2);
        dst = (op == 6'd0) ? imm[15:11] : rs2;
        wen = v && (op <= 6'd2) && (dst != 5'd0);
        res = a + b;
        if (ld) res = res ^ 32'h5A5A_0000;
        if (wen) golden[dst] = res;
        for (int k = 2; k > 0; k--) begin
            h_wen[k] = h_wen[k-1]; h_ld[k] = h_ld[k-1];
            h_dst[k] = h_dst[k-1]; h_val[k] = h_val[k-1];
        end
        h_wen[0] = wen; h_ld[0] = ld; h_dst[0] = dst; h_val[0] = res;
        sb_q.push_back(e);
    endtask

    task automatic rr(input logic [4:0] rd, input logic [4:0] s1, input logic [4:0] s2, input string tag);
        issue(1'b1, 6'd0, s1, s2, {rd, 11'd0}, tag);
    endtask

    task automatic bubble(input logic [4:0] s1, input string tag);
        issue(1'b0, 6'd0, s1, s1, {s1, 11'd0}, tag);
    endtask

    // monitor: compare the slot that entered execute at this edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, "sel_a",  {30'd0, sel_a},  {30'd0, e.sa});
                check(e.tag, "sel_b",  {30'd0, sel_b},  {30'd0, e.sb});
                check(e.tag, "sel_sd", {30'd0, sel_sd}, {30'd0, e.ssd});
                if (e.chk_v) begin
                    check(e.tag, "opnd_a", ex_opnd_a, e.va);
                    check(e.tag, "opnd_b", ex_opnd_b, e.vb);
                end
                if (e.chk_sd) check(e.tag, "store_data", ex_store_data, e.vsd);
            end
        end
    end

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; id_valid = 1'b0; id_instr = '0;
        id_rs1_data = '0; id_rs2_data = '0; mem_rdata = '0;
        for (int k = 0; k < 32; k++) begin
            golden[k] = (k == 0) ? 32'h0 : (32'h1000 * k + k);
            lagged[k] = golden[k];
        end
        for (int k = 0; k < 3; k++) begin
            h_wen[k] = 0; h_ld[k] = 0; h_dst[k] = '0; h_val[k] = '0;
        end
        id_rs1_data = 32'hDEAD_BEEF;
        id_valid    = 1'b1;
        repeat (3) @(negedge clk);
        // R11: reset holds everything empty
        check("R11", "sel_a",  {30'd0, sel_a},  32'd0);
        check("R11", "sel_b",  {30'd0, sel_b},  32'd0);
        check("R11", "sel_sd", {30'd0, sel_sd}, 32'd0);
        check("R11", "opnd_a", ex_opnd_a, 32'd0);
        id_valid = 1'b0; id_rs1_data = '0;
        rst_n = 1'b1;

        rr(5'd1, 5'd2, 5'd3, "R12");            // r1 = r2 + r3
        rr(5'd4, 5'd1, 5'd5, "R3");             // A from execute/memory
        rr(5'd6, 5'd7, 5'd1, "R4");             // B from memory/writeback
        rr(5'd8, 5'd1, 5'd9, "R6");             // three slots older: register file
        issue(1'b1, 6'd1, 5'd2, 5'd10, 16'd5, "R2");   // RI writes [20:16]
        issue(1'b1, 6'd1, 5'd3, 5'd10, 16'hFFF9, "R2");
        rr(5'd11, 5'd10, 5'd10, "R4");          // both match: younger wins
        rr(5'd0, 5'd2, 5'd3, "R5");             // write to r0
        rr(5'd12, 5'd0, 5'd0, "R5");            // r0 never forwarded
        issue(1'b1, 6'd2, 5'd2, 5'd13, 16'd4, "R12");  // load r13
        bubble(5'd13, "R10");
        issue(1'b1, 6'd3, 5'd2, 5'd13, 16'd8, "R8");   // store data from load
        issue(1'b1, 6'd2, 5'd3, 5'd14, 16'd12, "R12"); // load r14
        bubble(5'd0, "R10");
        rr(5'd15, 5'd14, 5'd14, "R4");          // load data into ALU
        rr(5'd16, 5'd2, 5'd5, "R3");
        issue(1'b1, 6'd3, 5'd16, 5'd16, 16'h0010, "R8"); // store data from ALU result
        rr(5'd17, 5'd3, 5'd4, "R7");
        issue(1'b1, 6'd1, 5'd17, 5'd18, 16'h8001, "R7"); // B is immediate, not forwarded
        issue(1'b1, 6'd2, 5'd2, 5'd19, 16'd0, "R9");     // load r19
        issue(1'b1, 6'd5, 5'd19, 5'd0, 16'd0, "R9");     // consumer in execute
        issue(1'b1, 6'd1, 5'd4, 5'd20, 16'd3, "R9");     // RI r20
        issue(1'b1, 6'd2, 5'd5, 5'd20, 16'd0, "R9");     // load r20 over it
        issue(1'b1, 6'd4, 5'd20, 5'd0, 16'd0, "R9");     // falls to older writer
        bubble(5'd0, "R10");
        bubble(5'd0, "R10");
        issue(1'b0, 6'd0, 5'd2, 5'd3, {5'd21, 11'd0}, "R10"); // invalid producer
        rr(5'd22, 5'd21, 5'd21, "R10");
        issue(1'b1, 6'd3, 5'd2, 5'd23, 16'd0, "R2");     // store writes nothing
        issue(1'b1, 6'd4, 5'd3, 5'd24, 16'd0, "R2");     // other class writes nothing
        rr(5'd25, 5'd23, 5'd24, "R2");
        rr(5'd26, 5'd2, 5'd27, "R2");                    // RR does not write [20:16]
        rr(5'd28, 5'd27, 5'd26, "R3");
        issue(1'b1, 6'd1, 5'd0, 5'd29, 16'h7FFF, "R1");
        rr(5'd30, 5'd29, 5'd28, "R1");
        bubble(5'd0, "R10");
        bubble(5'd0, "R10");
        bubble(5'd0, "R10");
        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        summary();
        $finish;
    end
endmodule